// File: doc/BRIEF.md
# Divider Tap Selector and Square-Wave Generator

This block turns a 32.768 kHz timing enable into the slower rhythms a real-time clock needs. A 15-stage binary divider advances once for every clock cycle in which the timing enable is high. A 4-bit rate code picks one stage of that divider. The chosen stage drives a square-wave pin and also produces a one-cycle periodic-event pulse on each of its rising edges. The last stage produces a one-second update tick.

A 3-bit oscillator control field sets how the divider behaves. One pattern lets it count. Two patterns clear it and keep it at zero. All other patterns freeze it. Because the divider leaves the cleared state at zero, the first update tick comes half a second after counting starts, and later ticks come once a second. The rate code, oscillator control and square-wave enable are captured in registers on every clock edge. Reset clears those captured settings, so after reset the divider is stopped, no rate is selected and the square wave is disabled.

Top module: `tap_rate_gen`

## Requirements
- R1: Rate code 0 selects no stage. `sqwOut` stays 0 and `periodicPulse` never fires, even while the divider counts.
- R2: Rate codes 3 to 15 select a square wave whose period is 2^(code-1) counted enables. Code 3 gives a period of 4 (8.192 kHz) and code 15 gives a period of 16384 (2 Hz). Starting from a cleared divider, `sqwOut` is high exactly when (enables counted mod period) >= period/2.
- R3: Rate codes 1 and 2 behave exactly like codes 8 and 9, with periods of 128 and 256 enables (256 Hz and 128 Hz).
- R4: While the captured `sqwEn` is 0, `sqwOut` is held at 0 and `periodicPulse` keeps firing at the selected rate.
- R5: `periodicPulse` is high for exactly one clock cycle per square-wave period. It fires in the cycle where the selected stage rises, so from a cleared divider the first pulse comes after period/2 enables and the next after 3*period/2 enables.
- R6: The oscillator control field selects the divider mode. Pattern 3'b010 counts. Patterns 3'b110 and 3'b111 clear the divider and keep it at zero, with no pulse, no tick and `sqwOut` low. Every other pattern freezes the divider, so `sqwOut` keeps its level and no pulse or tick occurs.
- R7: `secTick` is a one-cycle pulse. Counting from a cleared divider, it first fires after 16384 enables and then after every further 32768 enables.
- R8: Asynchronous reset (`rst_n` low) clears the divider and the captured settings (rate 0, square wave disabled, oscillator stopped) and forces `sqwOut` low. Input values take effect one clock edge after they are sampled.
- R9: The divider advances only on clock cycles where `tickEn` is 1. A cycle with `tickEn` at 0 changes no output and produces no pulse or tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | 32.768 kHz timing enable, one cycle wide |
| rateSel | input | 4 | Rate code that picks the divider stage |
| oscCtl | input | 3 | Oscillator and divider control pattern |
| sqwEn | input | 1 | Square-wave output enable |
| sqwOut | output | 1 | Square-wave pin |
| periodicPulse | output | 1 | One-cycle pulse on each rising edge of the selected stage |
| secTick | output | 1 | One-cycle update tick, once per second |

## Verification
The bench builds the block with its default 15-stage divider and holds `tickEn` high on every counting cycle. Half a second of device time then takes 16384 clock cycles and a full second takes 32768. This keeps every rate code, including the 2 Hz endpoint and the duplicated low codes, within reach for two full periods from a cleared divider. It also allows the first update tick and one further full second to be timed exactly. Freeze, hold, idle-enable and mid-run reset cases are driven as directed sequences, each timed from a known divider count.

// File: rtl/tap_rate_pkg.sv
package tap_rate_pkg;

  localparam int DIV_STAGES = 15;
  localparam int RATE_W     = 4;
  localparam int OSC_W      = 3;
  localparam int TAP_IDX_W  = $clog2(DIV_STAGES);

  typedef enum logic [1:0] {
    OSC_STOP = 2'd0,
    OSC_HOLD = 2'd1,
    OSC_RUN  = 2'd2
  } oscMode_e;

  // Strobes from control to the divider datapath
  typedef struct packed {
    logic                 countEn;
    logic                 clearDiv;
    logic                 tapValid;
    logic [TAP_IDX_W-1:0] tapIdx;
  } divStrobe_t;

endpackage

// File: rtl/rate_ctrl.sv
module rate_ctrl
  import tap_rate_pkg::*;
#(
  parameter int RATE_BITS = RATE_W,
  parameter int OSC_BITS  = OSC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tickEn,
  input  logic [RATE_BITS-1:0] rateSel,
  input  logic [OSC_BITS-1:0]  oscCtl,
  input  logic                 sqwEn,
  output divStrobe_t           strobe,
  output logic                 sqwGate
);

  // Low codes alias the codes ALIAS_SHIFT above them
  localparam int ALIAS_SHIFT = 7;
  localparam int LOW_ALIAS   = 2;
  localparam int TAP_OFFSET  = 2;
  localparam logic [OSC_BITS-1:0] RUN_PATTERN = OSC_BITS'(3'b010);

  logic [RATE_BITS-1:0] rateQ;
  logic [OSC_BITS-1:0]  oscQ;
  logic                 sqwEnQ;
  oscMode_e             oscMode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rateQ  <= '0;
      oscQ   <= '0;
      sqwEnQ <= 1'b0;
    end else begin
      rateQ  <= rateSel;
      oscQ   <= oscCtl;
      sqwEnQ <= sqwEn;
    end
  end

  always_comb begin
    if (oscQ == RUN_PATTERN)
      oscMode = OSC_RUN;
    else if (oscQ[OSC_BITS-1] && oscQ[OSC_BITS-2])
      oscMode = OSC_HOLD;
    else
      oscMode = OSC_STOP;
  end

  function automatic logic [TAP_IDX_W-1:0] tapOf(input logic [RATE_BITS-1:0] code);
    int c;
    c = int'(code);
    if (c <= LOW_ALIAS)
      c = c + ALIAS_SHIFT;
    return TAP_IDX_W'(c - TAP_OFFSET);
  endfunction

  always_comb begin
    strobe.countEn  = (oscMode == OSC_RUN) && tickEn;
    strobe.clearDiv = (oscMode == OSC_HOLD);
    strobe.tapValid = (rateQ != '0);
    strobe.tapIdx   = (rateQ != '0) ? tapOf(rateQ) : '0;
  end

  assign sqwGate = sqwEnQ;

endmodule

// File: rtl/div_chain.sv
module div_chain
  import tap_rate_pkg::*;
#(
  parameter int DIV_W = DIV_STAGES
) (
  input  logic       clk,
  input  logic       rst_n,
  input  divStrobe_t strobe,
  output logic       divTap,
  output logic       periodicPulse,
  output logic       secTick
);

  localparam int TICK_BIT = DIV_W - 1;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divNext;
  logic [DIV_W-1:0] riseAt;

  assign divNext = divCnt + DIV_W'(1);

  // riseAt[k]: the next count makes stage k rise (bit k set, all lower bits clear)
  for (genvar k = 0; k < DIV_W; k++) begin : g_rise
    localparam logic [DIV_W-1:0] LOW_MASK = (DIV_W'(1) << k) - DIV_W'(1);
    assign riseAt[k] = divNext[k] & ~|(divNext & LOW_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt        <= '0;
      periodicPulse <= 1'b0;
      secTick       <= 1'b0;
    end else if (strobe.clearDiv) begin
      divCnt        <= '0;
      periodicPulse <= 1'b0;
      secTick       <= 1'b0;
    end else if (strobe.countEn) begin
      divCnt        <= divNext;
      periodicPulse <= strobe.tapValid & riseAt[strobe.tapIdx];
      secTick       <= riseAt[TICK_BIT];
    end else begin
      periodicPulse <= 1'b0;
      secTick       <= 1'b0;
    end
  end

  assign divTap = strobe.tapValid & divCnt[strobe.tapIdx];

endmodule

// File: rtl/tap_rate_gen.sv
module tap_rate_gen
  import tap_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [OSC_W-1:0]  oscCtl,
  input  logic              sqwEn,
  output logic              sqwOut,
  output logic              periodicPulse,
  output logic              secTick
);

  divStrobe_t strobe;
  logic       sqwGate;
  logic       divTap;

  rate_ctrl #(
    .RATE_BITS(RATE_W),
    .OSC_BITS (OSC_W)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .tickEn (tickEn),
    .rateSel(rateSel),
    .oscCtl (oscCtl),
    .sqwEn  (sqwEn),
    .strobe (strobe),
    .sqwGate(sqwGate)
  );

  div_chain #(
    .DIV_W(DIV_STAGES)
  ) u_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe       (strobe),
    .divTap       (divTap),
    .periodicPulse(periodicPulse),
    .secTick      (secTick)
  );

  assign sqwOut = sqwGate & divTap;

endmodule

// File: rtl/tap_rate_chk.sv
module tap_rate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tickEn,
  input logic [3:0] rateSel,
  input logic [2:0] oscCtl,
  input logic       sqwEn,
  input logic       sqwOut,
  input logic       periodicPulse,
  input logic       secTick
);

  AST_RATE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rateSel == 4'd0 && $past(rateSel) == 4'd0) |=> (!periodicPulse && !sqwOut)); // R1

  AST_SQW_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !sqwEn |=> !sqwOut); // R4

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    periodicPulse |=> !periodicPulse); // R5

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((oscCtl == 3'b110 || oscCtl == 3'b111) &&
     ($past(oscCtl) == 3'b110 || $past(oscCtl) == 3'b111))
    |=> (!periodicPulse && !secTick && !sqwOut)); // R6

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    secTick |=> !secTick); // R7

  AST_IDLE_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    !tickEn |=> (!periodicPulse && !secTick)); // R9

endmodule

bind tap_rate_gen tap_rate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tickEn       (tickEn),
  .rateSel      (rateSel),
  .oscCtl       (oscCtl),
  .sqwEn        (sqwEn),
  .sqwOut       (sqwOut),
  .periodicPulse(periodicPulse),
  .secTick      (secTick)
);

// File: tb/tb_tap_rate_gen.sv
module tb_tap_rate_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tickEn = 1'b0;
  logic [3:0] rateSel = 4'd0;
  logic [2:0] oscCtl = 3'b000;
  logic       sqwEn = 1'b0;
  logic       sqwOut;
  logic       periodicPulse;
  logic       secTick;

  int testCount = 0;
  int failCount = 0;

  always #10 clk = ~clk;

  tap_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .rateSel(rateSel),
    .oscCtl(oscCtl), .sqwEn(sqwEn), .sqwOut(sqwOut),
    .periodicPulse(periodicPulse), .secTick(secTick)
  );

  // Rate code and expected square-wave period in counted enables
  localparam int NVEC = 15;
  localparam logic [3:0] VEC_CODE [NVEC] =
    '{4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9, 4'd1, 4'd2,
      4'd10, 4'd11, 4'd12, 4'd13, 4'd14, 4'd15};
  localparam int VEC_PERIOD [NVEC] =
    '{4, 8, 16, 32, 64, 128, 256, 128, 256,
      512, 1024, 2048, 4096, 8192, 16384};

  task automatic check(input string req, input int act, input int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inputs change at a falling edge; outputs are sampled at the next falling edge
  task automatic step(input logic te);
    tickEn = te;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic configure(input logic [3:0] code, input logic en);
    rateSel = code;
    sqwEn   = en;
    oscCtl  = 3'b110;
    step(1'b0);
    step(1'b0);
    oscCtl  = 3'b010;
    step(1'b0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    int pulses, firstAt, mism, highs, ticks, tick1, tick2, lvl;
    repeat (3) @(negedge clk);
    // R8: outputs quiet while in reset
    check("R8 sqwOut in reset", int'(sqwOut), 0);
    check("R8 periodicPulse in reset", int'(periodicPulse), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table of rate codes: R2, R3, R5
    for (int i = 0; i < NVEC; i++) begin
      int p;
      p = VEC_PERIOD[i];
      configure(VEC_CODE[i], 1'b1);
      pulses = 0; firstAt = -1; mism = 0;
      for (int n = 1; n <= 2 * p; n++) begin
        step(1'b1);
        if (periodicPulse) begin
          pulses++;
          if (firstAt < 0) firstAt = n;
        end
        if (int'(sqwOut) != (((n % p) >= p / 2) ? 1 : 0)) mism++;
      end
      if (VEC_CODE[i] < 4'd3) begin
        check($sformatf("R3 first pulse code %0d", VEC_CODE[i]), firstAt, p / 2);
        check($sformatf("R3 sqw mismatches code %0d", VEC_CODE[i]), mism, 0);
      end else begin
        check($sformatf("R2 first pulse code %0d", VEC_CODE[i]), firstAt, p / 2);
        check($sformatf("R2 sqw mismatches code %0d", VEC_CODE[i]), mism, 0);
      end
      check($sformatf("R5 pulses in two periods code %0d", VEC_CODE[i]), pulses, 2);
    end

    // R7 and R1: code 0 for 1.5 seconds of enables
    configure(4'd0, 1'b1);
    pulses = 0; highs = 0; ticks = 0; tick1 = -1; tick2 = -1;
    for (int n = 1; n <= 49152; n++) begin
      step(1'b1);
      if (periodicPulse) pulses++;
      if (sqwOut) highs++;
      if (secTick) begin
        ticks++;
        if (tick1 < 0) tick1 = n; else tick2 = n;
      end
    end
    check("R1 pulses with code 0", pulses, 0);
    check("R1 sqwOut high cycles with code 0", highs, 0);
    check("R7 first tick enable index", tick1, 16384);
    check("R7 second tick enable index", tick2, 49152);
    check("R7 tick count", ticks, 2);

    // R4: enable off, pulses continue
    configure(4'd3, 1'b0);
    pulses = 0; highs = 0;
    for (int n = 1; n <= 8; n++) begin
      step(1'b1);
      if (periodicPulse) pulses++;
      if (sqwOut) highs++;
    end
    check("R4 sqwOut high while disabled", highs, 0);
    check("R4 pulses while disabled", pulses, 2);

    // R9: idle cycles do nothing
    configure(4'd3, 1'b1);
    step(1'b1);
    lvl = int'(sqwOut);
    pulses = 0; mism = 0;
    for (int n = 0; n < 20; n++) begin
      step(1'b0);
      if (periodicPulse) pulses++;
      if (int'(sqwOut) != lvl) mism++;
    end
    check("R9 pulses on idle cycles", pulses, 0);
    check("R9 sqwOut change on idle cycles", mism, 0);
    step(1'b1);
    check("R9 pulse on second enable", int'(periodicPulse), 1);
    check("R9 sqwOut after second enable", int'(sqwOut), 1);

    // R6: freeze keeps level, hold clears
    configure(4'd3, 1'b1);
    repeat (6) step(1'b1);
    check("R6 sqwOut at count 6", int'(sqwOut), 1);
    oscCtl = 3'b000;
    step(1'b0);
    pulses = 0; mism = 0;
    for (int n = 0; n < 10; n++) begin
      step(1'b1);
      if (periodicPulse) pulses++;
      if (sqwOut !== 1'b1) mism++;
    end
    check("R6 pulses while frozen", pulses, 0);
    check("R6 sqwOut drift while frozen", mism, 0);
    oscCtl = 3'b010;
    step(1'b0);
    step(1'b1);
    check("R6 sqwOut at count 7 after resume", int'(sqwOut), 1);
    step(1'b1);
    check("R6 sqwOut at count 8 after resume", int'(sqwOut), 0);
    step(1'b1);
    step(1'b1);
    check("R6 pulse at count 10 after resume", int'(periodicPulse), 1);
    oscCtl = 3'b111;
    step(1'b0);
    step(1'b0);
    pulses = 0; highs = 0;
    for (int n = 0; n < 8; n++) begin
      step(1'b1);
      if (periodicPulse) pulses++;
      if (sqwOut) highs++;
    end
    check("R6 pulses while held", pulses, 0);
    check("R6 sqwOut high while held", highs, 0);

    // R8: mid-run reset clears divider and settings
    configure(4'd3, 1'b1);
    step(1'b1);
    step(1'b1);
    check("R8 sqwOut high before reset", int'(sqwOut), 1);
    rst_n = 1'b0;
    #1;
    check("R8 sqwOut during reset", int'(sqwOut), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R8 sqwOut after release, settings cleared", int'(sqwOut), 0);
    @(negedge clk);
    step(1'b0);
    step(1'b1);
    check("R8 no pulse at count 1 after reset", int'(periodicPulse), 0);
    step(1'b1);
    check("R8 pulse at count 2 after reset", int'(periodicPulse), 1);
    check("R8 sqwOut at count 2 after reset", int'(sqwOut), 1);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule